// File: doc/BRIEF.md
# DMA Control-Port Read-Back Sequencer

This block answers CPU reads from the control port of a byte-wide DMA controller. When software asks for it, the block takes a snapshot of selected live engine state into a short read buffer. That state is the status byte, the running byte counter and the current addresses of the two ports. Successive reads then step through the snapshot one byte at a time.

A 7-bit read mask chooses which bytes go into the buffer. Three pulses rebuild the buffer from the current mask and the current inputs: the read-status command, the initiate-read-sequence command and a write of a new read mask. The status byte is assembled from the stored status register together with two live conditions. Its flags are active-low, so a cleared bit means that the event has happened. When the buffer holds nothing, a read returns the live status byte.

Command decoding and the transfer engine sit outside this block. It only sees their pulses and their live values.

Top module: `dma_readback_seq`

## Requirements
- R1: After reset the buffer is empty and `rd_data` shows the live status byte.
- R2: The status byte is `stat_reg` ORed with 0x02 while `ready_act` is 0 and with 0x08 while `irq_pend` is 0.
- R3: A rebuild stores one entry per set bit of `rd_mask`, in ascending bit order. Bit 0 is status, bit 1 is counter low, bit 2 is counter high, bit 3 is port A address low, bit 4 is port A address high, bit 5 is port B address low and bit 6 is port B address high.
- R4: Entries are a snapshot taken at the rebuild edge. Later changes of `stat_reg`, `ready_act`, `irq_pend`, `xfer_count`, `cur_addr_a` or `cur_addr_b` do not alter them before the next rebuild.
- R5: Each clock edge with `rd_strobe` high and a non-empty buffer moves to the next entry. After the last entry it wraps back to the first one.
- R6: `cmd_status_pulse`, `cmd_seq_pulse` and `mask_wr_pulse` each rebuild the buffer using the `rd_mask` value present on that edge. After the rebuild the first entry is shown.
- R7: With an empty buffer (mask 0), `rd_strobe` has no effect and `rd_data` follows the live status byte.
- R8: Status bits 4 (match) and 5 (end of block) are copied unchanged from `stat_reg`, active-low.
- R9: A rebuild pulse and `rd_strobe` on the same edge give a rebuilt buffer showing its first entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | One CPU read of the control port consumed per cycle |
| cmd_status_pulse | input | 1 | Read-status command decoded |
| cmd_seq_pulse | input | 1 | Initiate-read-sequence command decoded |
| mask_wr_pulse | input | 1 | New read mask written |
| rd_mask | input | 7 | Read mask selecting buffer entries |
| stat_reg | input | 8 | Stored status register (active-low flags) |
| ready_act | input | 1 | Ready condition, already polarity-resolved, 1 = ready |
| irq_pend | input | 1 | Interrupt pending |
| xfer_count | input | 16 | Live byte counter |
| cur_addr_a | input | 16 | Live port A address |
| cur_addr_b | input | 16 | Live port B address |
| rd_data | output | 8 | Read data for the current read |

## Verification
The packing is tried with a sparse mask of alternate bits, a contiguous pair, a full mask and an empty mask. These show whether the entries are compacted in the correct bit order, whether high and low halves are swapped, and whether an empty buffer falls back to live status. The status byte is driven through all four ready and interrupt combinations, and with event flags both set and cleared, so that each OR term and the untouched flag bits are seen on their own. Snapshot, wrap, pointer restart and same-edge collision scenarios separate a live mux from a captured buffer, and a rebuild from a plain read.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
   localparam int NUM_FIELDS = 7;

   typedef enum logic [2:0] {
      FLD_STATUS = 3'd0,
      FLD_CNT_LO = 3'd1,
      FLD_CNT_HI = 3'd2,
      FLD_A_LO   = 3'd3,
      FLD_A_HI   = 3'd4,
      FLD_B_LO   = 3'd5,
      FLD_B_HI   = 3'd6
   } field_e;
endpackage

// File: rtl/rb_status_fmt.sv
module rb_status_fmt #(
   parameter int DATA_W    = 8,
   parameter int READY_BIT = 1,
   parameter int IRQ_BIT   = 3
) (
   input  logic [DATA_W-1:0] flags,
   input  logic              ready,
   input  logic              irq,
   output logic [DATA_W-1:0] status_byte
);
   logic [DATA_W-1:0] not_ready_term;
   logic [DATA_W-1:0] no_irq_term;

   always_comb begin
      not_ready_term = '0;
      no_irq_term    = '0;
      not_ready_term[READY_BIT] = ~ready;
      no_irq_term[IRQ_BIT]      = ~irq;
      status_byte = flags | not_ready_term | no_irq_term;
   end
endmodule

// File: rtl/rb_entry_pack.sv
module rb_entry_pack
   import dmarb_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int WORD_W = 16,
   localparam int DEPTH = NUM_FIELDS,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic [DEPTH-1:0]             mask,
   input  logic [DATA_W-1:0]            status_byte,
   input  logic [WORD_W-1:0]            count,
   input  logic [WORD_W-1:0]            addr_a,
   input  logic [WORD_W-1:0]            addr_b,
   output logic [DEPTH-1:0][DATA_W-1:0] packed_q,
   output logic [CW-1:0]                packed_n
);
   localparam int NWORDS = 3;

   logic [DEPTH-1:0][DATA_W-1:0] src;
   logic [NWORDS-1:0][WORD_W-1:0] words;

   assign words[0] = count;
   assign words[1] = addr_a;
   assign words[2] = addr_b;
   assign src[FLD_STATUS] = status_byte;

   // each 16-bit word supplies two consecutive fields: low byte first
   for (genvar w = 0; w < NWORDS; w++) begin : g_split
      assign src[1 + 2*w]     = words[w][DATA_W-1:0];
      assign src[1 + 2*w + 1] = words[w][WORD_W-1:DATA_W];
   end

   always_comb begin
      logic [CW-1:0] slot;
      slot     = '0;
      packed_q = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (mask[j]) begin
            packed_q[slot] = src[j];
            slot = slot + 1'b1;
         end
      end
      packed_n = slot;
   end
endmodule

// File: rtl/rb_buffer.sv
module rb_buffer #(
   parameter int DATA_W        = 8,
   parameter int DEPTH         = 7,
   parameter bit LIVE_FALLBACK = 1'b1,
   localparam int CW           = $clog2(DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load,
   input  logic                         advance,
   input  logic [DEPTH-1:0][DATA_W-1:0] load_data,
   input  logic [CW-1:0]                load_n,
   input  logic [DATA_W-1:0]            live_status,
   output logic [CW-1:0]                cnt,
   output logic [CW-1:0]                ptr,
   output logic [DATA_W-1:0]            dout
);
   logic [DEPTH-1:0][DATA_W-1:0] mem_q;
   logic [DATA_W-1:0]            empty_val;
   logic                         at_last;

   assign at_last = (ptr == cnt - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q <= '0;
         cnt   <= '0;
         ptr   <= '0;
      end else if (load) begin
         mem_q <= load_data;
         cnt   <= load_n;
         ptr   <= '0;
      end else if (advance && cnt != '0) begin
         ptr <= at_last ? '0 : ptr + 1'b1;
      end
   end

   if (LIVE_FALLBACK) begin : g_live
      assign empty_val = live_status;
   end else begin : g_zero
      assign empty_val = '0;
   end

   assign dout = (cnt == '0) ? empty_val : mem_q[ptr[$clog2(DEPTH)-1:0]];
endmodule

// File: rtl/dma_readback_seq.sv
module dma_readback_seq
   import dmarb_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int WORD_W        = 16,
   parameter int READY_BIT     = 1,
   parameter int IRQ_BIT       = 3,
   parameter bit LIVE_FALLBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_strobe,
   input  logic              cmd_status_pulse,
   input  logic              cmd_seq_pulse,
   input  logic              mask_wr_pulse,
   input  logic [6:0]        rd_mask,
   input  logic [DATA_W-1:0] stat_reg,
   input  logic              ready_act,
   input  logic              irq_pend,
   input  logic [WORD_W-1:0] xfer_count,
   input  logic [WORD_W-1:0] cur_addr_a,
   input  logic [WORD_W-1:0] cur_addr_b,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = NUM_FIELDS;
   localparam int CW    = $clog2(DEPTH + 1);

   if (WORD_W != 2 * DATA_W) begin : g_bad_word
      $error("WORD_W must be twice DATA_W");
   end
   if (READY_BIT >= DATA_W || IRQ_BIT >= DATA_W || READY_BIT == IRQ_BIT) begin : g_bad_bits
      $error("READY_BIT and IRQ_BIT must be distinct bits inside DATA_W");
   end

   logic [DATA_W-1:0]            live_status;
   logic [DEPTH-1:0][DATA_W-1:0] packed_q;
   logic [CW-1:0]                packed_n;
   logic [CW-1:0]                buf_cnt;
   logic [CW-1:0]                rd_ptr;
   logic                         rebuild;

   assign rebuild = cmd_status_pulse | cmd_seq_pulse | mask_wr_pulse;

   rb_status_fmt #(
      .DATA_W(DATA_W), .READY_BIT(READY_BIT), .IRQ_BIT(IRQ_BIT)
   ) u_fmt (
      .flags(stat_reg), .ready(ready_act), .irq(irq_pend),
      .status_byte(live_status)
   );

   rb_entry_pack #(
      .DATA_W(DATA_W), .WORD_W(WORD_W)
   ) u_pack (
      .mask(rd_mask), .status_byte(live_status), .count(xfer_count),
      .addr_a(cur_addr_a), .addr_b(cur_addr_b),
      .packed_q(packed_q), .packed_n(packed_n)
   );

   rb_buffer #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .LIVE_FALLBACK(LIVE_FALLBACK)
   ) u_buf (
      .clk(clk), .rst_n(rst_n), .load(rebuild), .advance(rd_strobe),
      .load_data(packed_q), .load_n(packed_n), .live_status(live_status),
      .cnt(buf_cnt), .ptr(rd_ptr), .dout(rd_data)
   );
endmodule

// File: rtl/dma_readback_seq_chk.sv
module dma_readback_seq_chk #(
   parameter int DATA_W    = 8,
   parameter int READY_BIT = 1,
   parameter int IRQ_BIT   = 3,
   parameter int CW        = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_strobe,
   input logic              cmd_status_pulse,
   input logic              cmd_seq_pulse,
   input logic              mask_wr_pulse,
   input logic [6:0]        rd_mask,
   input logic [DATA_W-1:0] stat_reg,
   input logic              ready_act,
   input logic              irq_pend,
   input logic [DATA_W-1:0] rd_data,
   input logic [CW-1:0]     buf_cnt,
   input logic [CW-1:0]     rd_ptr
);
   logic any_load;
   assign any_load = cmd_status_pulse | cmd_seq_pulse | mask_wr_pulse;

   // R2
   empty_ready_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_cnt == '0) |-> (rd_data[READY_BIT] == (stat_reg[READY_BIT] | ~ready_act)));

   // R2
   empty_irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_cnt == '0) |-> (rd_data[IRQ_BIT] == (stat_reg[IRQ_BIT] | ~irq_pend)));

   // R8
   event_flags_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_cnt == '0) |-> (rd_data[5:4] == stat_reg[5:4]));

   // R3
   entry_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_load |=> (buf_cnt == CW'($countones($past(rd_mask)))));

   // R4
   snapshot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_load && !rd_strobe && buf_cnt != '0) |=> $stable(rd_data));

   // R5
   ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_load && rd_strobe && buf_cnt != '0 && rd_ptr == buf_cnt - 1'b1) |=> (rd_ptr == '0));

   // R5
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_cnt == '0) || (rd_ptr < buf_cnt));

   // R6
   rebuild_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_load |=> (rd_ptr == '0));

   // R9
   rebuild_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_load && rd_strobe) |=> (rd_ptr == '0));
endmodule

bind dma_readback_seq dma_readback_seq_chk #(
   .DATA_W(DATA_W), .READY_BIT(READY_BIT), .IRQ_BIT(IRQ_BIT), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
   .cmd_status_pulse(cmd_status_pulse), .cmd_seq_pulse(cmd_seq_pulse),
   .mask_wr_pulse(mask_wr_pulse), .rd_mask(rd_mask), .stat_reg(stat_reg),
   .ready_act(ready_act), .irq_pend(irq_pend), .rd_data(rd_data),
   .buf_cnt(buf_cnt), .rd_ptr(rd_ptr)
);

// File: tb/dma_readback_seq_bench.sv
module dma_readback_seq_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_strobe = 1'b0;
   logic        cmd_status_pulse = 1'b0;
   logic        cmd_seq_pulse = 1'b0;
   logic        mask_wr_pulse = 1'b0;
   logic [6:0]  rd_mask = '0;
   logic [7:0]  stat_reg = 8'h30;
   logic        ready_act = 1'b1;
   logic        irq_pend = 1'b1;
   logic [15:0] xfer_count = 16'h1234;
   logic [15:0] cur_addr_a = 16'hA55A;
   logic [15:0] cur_addr_b = 16'h0F81;
   logic [7:0]  rd_data;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   dma_readback_seq u_dma_readback_seq (
      .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
      .cmd_status_pulse(cmd_status_pulse), .cmd_seq_pulse(cmd_seq_pulse),
      .mask_wr_pulse(mask_wr_pulse), .rd_mask(rd_mask), .stat_reg(stat_reg),
      .ready_act(ready_act), .irq_pend(irq_pend), .xfer_count(xfer_count),
      .cur_addr_a(cur_addr_a), .cur_addr_b(cur_addr_b), .rd_data(rd_data)
   );

   function automatic logic [7:0] exp_status(logic [7:0] f, logic rdy, logic irq);
      return f | (rdy ? 8'h00 : 8'h02) | (irq ? 8'h00 : 8'h08);
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   // sample current entry, then consume it with one strobe edge
   task automatic do_read(output logic [7:0] d);
      @(negedge clk);
      d = rd_data;
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
   endtask

   task automatic pulse_load(int which, logic [6:0] m);
      @(negedge clk);
      rd_mask = m;
      case (which)
         0: cmd_status_pulse = 1'b1;
         1: cmd_seq_pulse = 1'b1;
         default: mask_wr_pulse = 1'b1;
      endcase
      @(negedge clk);
      cmd_status_pulse = 1'b0;
      cmd_seq_pulse = 1'b0;
      mask_wr_pulse = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      @(negedge clk);
      chk("R1 reset live status", rd_data, 8'h30);
      do_read(d);
      chk("R1 read after reset", d, 8'h30);
   endtask

   task automatic t_status_compose();
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         ready_act = k[0];
         irq_pend = k[1];
         #1;
         chk("R2 status combination", rd_data, exp_status(8'h30, k[0], k[1]));
      end
      stat_reg = 8'h00;
      #1;
      chk("R8 event flags cleared", rd_data, 8'h00 | 8'h00);
      ready_act = 1'b1; irq_pend = 1'b1;
      stat_reg = 8'h20;
      #1;
      chk("R8 match event only", rd_data, 8'h20);
      stat_reg = 8'h30;
   endtask

   task automatic t_sparse_order();
      logic [7:0] d;
      pulse_load(2, 7'b0101010);
      do_read(d); chk("R3 sparse slot0 cnt lo", d, 8'h34);
      do_read(d); chk("R3 sparse slot1 a lo", d, 8'h5A);
      do_read(d); chk("R3 sparse slot2 b lo", d, 8'h81);
      do_read(d); chk("R5 wrap to first", d, 8'h34);
   endtask

   task automatic t_full_mask();
      logic [7:0] d;
      logic [7:0] exp [7];
      ready_act = 1'b0;
      exp[0] = exp_status(8'h30, 1'b0, 1'b1);
      exp[1] = 8'h34; exp[2] = 8'h12; exp[3] = 8'h5A;
      exp[4] = 8'hA5; exp[5] = 8'h81; exp[6] = 8'h0F;
      pulse_load(1, 7'h7F);
      ready_act = 1'b1;
      for (int i = 0; i < 7; i++) begin
         do_read(d);
         chk("R3 full mask entry", d, exp[i]);
      end
      do_read(d);
      chk("R5 full wrap", d, exp[0]);
   endtask

   task automatic t_snapshot();
      logic [7:0] d;
      pulse_load(2, 7'b0000110);
      xfer_count = 16'hBEEF;
      do_read(d); chk("R4 snapshot cnt lo", d, 8'h34);
      do_read(d); chk("R4 snapshot cnt hi", d, 8'h12);
      pulse_load(0, 7'b0000110);
      do_read(d); chk("R6 status cmd rebuild lo", d, 8'hEF);
      do_read(d); chk("R6 status cmd rebuild hi", d, 8'hBE);
      xfer_count = 16'h1234;
   endtask

   task automatic t_restart();
      logic [7:0] d;
      pulse_load(2, 7'b0011000);
      do_read(d); chk("R6 pair first", d, 8'h5A);
      pulse_load(1, 7'b0011000);
      do_read(d); chk("R6 seq cmd restarts pointer", d, 8'h5A);
      do_read(d); chk("R6 pair second", d, 8'hA5);
   endtask

   task automatic t_collision();
      logic [7:0] d;
      pulse_load(2, 7'b1100000);
      do_read(d); chk("R9 before collision", d, 8'h81);
      @(negedge clk);
      chk("R9 pointer moved", rd_data, 8'h0F);
      cmd_seq_pulse = 1'b1;
      rd_strobe = 1'b1;
      @(negedge clk);
      cmd_seq_pulse = 1'b0;
      rd_strobe = 1'b0;
      chk("R9 rebuild wins over read", rd_data, 8'h81);
   endtask

   task automatic t_empty_mask();
      logic [7:0] d;
      pulse_load(2, 7'b0000000);
      do_read(d); chk("R7 empty gives status", d, 8'h30);
      ready_act = 1'b0;
      irq_pend = 1'b0;
      do_read(d); chk("R7 empty follows live status", d, 8'h3A);
      ready_act = 1'b1;
      irq_pend = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_status_compose();
      t_sparse_order();
      t_full_mask();
      t_snapshot();
      t_restart();
      t_collision();
      t_empty_mask();
      finish_run();
   end

   initial begin
      #(CLK_P * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end
endmodule